// File: doc/BRIEF.md
# Cipher-Mode DMA Trigger Sequencer

This block sits beside a 128-bit block-cipher core and raises three DMA request lines, one at a time, so that a DMA controller can move each block into and out of the core's registers without software help. A block is moved as a series of 16-bit accesses, and the sequencer decides which request line asks for the next access and which register that access must touch. The order depends on the chaining mode (ECB, CBC, OFB, with CFB decoded but not sequenced) and on the encrypt/decrypt direction.

While the chain enable is low, the sequencer stays idle. When the enable is raised, it samples the mode and the operation. In ECB it first requests the initial input block. It then waits for the core's done pulse. Each done pulse starts one pass through the phase list for the sampled mode. In every phase the request line is held until the DMA strobes the matching register. The line then drops for one cycle before it asks again.

Top module: `cmseq_trigger_seq`

## Requirements
- R1: While `rst` is high, and in any cycle after a clock edge at which `chain_en` was low, all `trig` bits are 0. Strobes and `core_done` have no effect then.
- R2: No more than one `trig` bit is high in any cycle, and phase k of every sequence uses `trig[k]`.
- R3: With `mode`=00 (ECB), on enable `trig[1]` serves `din_wr` first. After each `core_done`, `trig[0]` serves `dout_rd`, then `trig[1]` serves `din_wr`. `trig[2]` is never raised.
- R4: With `mode`=01 (CBC) and `op[0]`=0 (encrypt), each `core_done` starts `trig[0]` serving `dout_rd`, then `trig[1]` serving `xdin_wr`.
- R5: With `mode`=01 and `op[0]`=1 (decrypt, `op` 01 or 11), each `core_done` starts `trig[0]` serving `xin_wr`, then `trig[1]` serving `dout_rd`, then `trig[2]` serving `din_wr`.
- R6: With `mode`=10 (OFB), in either direction, each `core_done` starts `trig[0]` serving `xin_wr`, then `trig[1]` serving `dout_rd`, then `trig[2]` serving `xdin_wr`.
- R7: With `mode`=11 (CFB), no trigger is ever raised.
- R8: A raised trigger stays high until its own register's strobe is sampled. It is then low for exactly one cycle before the next request. Strobes for other registers, or strobes while no trigger is high, are not counted.
- R9: Each phase serves exactly BEATS (default 8) accesses before the next phase starts.
- R10: `core_done` is ignored while a sequence is in progress. After the last access of a pass, the next `core_done` starts a new pass.
- R11: A high `soft_rst` or a low `chain_en` clears every trigger on the next cycle, with all progress lost. The next pass starts again from the first access of its first phase.
- R12: `mode` and `op` are sampled only at the edge that leaves idle. Changing them while enabled has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of the sequence |
| chain_en | input | 1 | Enables DMA triggering |
| mode | input | 2 | Chaining mode: 00 ECB, 01 CBC, 10 OFB, 11 CFB |
| op | input | 2 | Operation; bit 0 high selects decrypt |
| core_done | input | 1 | One-cycle pulse when the cipher core finishes a block |
| dout_rd | input | 1 | Strobe for a 16-bit read of the data-out register |
| din_wr | input | 1 | Strobe for a 16-bit write of the data-in register |
| xin_wr | input | 1 | Strobe for a 16-bit write of the xor-input register |
| xdin_wr | input | 1 | Strobe for a 16-bit write of the xor-data-in register |
| trig | output | 3 | Registered DMA request lines, at most one high |

## Verification
Each chaining mode is run with its own phase list, and the CBC decrypt and OFB runs use different operation codes. Together they separate direction-dependent routing from mode-dependent routing, and they confirm that op value 11 counts as decrypt. Wrong-register strobes during a raised trigger, strobes during waiting, and a stray done pulse mid-pass show whether only the matching access advances the count. A soft reset in mid-phase, a mode change while enabled, and a CFB pass test restart, mode sampling and the silent mode. A behavioural queue model predicts the trigger lines on every clock.

// File: rtl/cmseq_pkg.sv
package cmseq_pkg;
  localparam int NUM_TRIG = 3;
  localparam int NUM_SRC  = 4;

  typedef enum logic [1:0] {
    MODE_ECB = 2'b00,
    MODE_CBC = 2'b01,
    MODE_OFB = 2'b10,
    MODE_CFB = 2'b11
  } cm_mode_e;

  // index into the strobe vector {xdin, xin, din, dout}
  typedef enum logic [1:0] {
    SRC_DOUT = 2'd0,
    SRC_DIN  = 2'd1,
    SRC_XIN  = 2'd2,
    SRC_XDIN = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_RUN
  } seq_st_e;

  function automatic logic [NUM_TRIG-1:0] trig_onehot(input logic [1:0] idx);
    return NUM_TRIG'(1) << idx;
  endfunction
endpackage

// File: rtl/cmseq_step_decode.sv
module cmseq_step_decode
  import cmseq_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  cm_mode_e        mode,
  input  logic            decrypt,
  input  logic            load,
  input  logic [PH_W-1:0] ph,
  output src_e            src,
  output logic [1:0]      trg,
  output logic            last,
  output logic            no_seq
);
  always_comb begin
    trg    = 2'(ph);
    src    = SRC_DOUT;
    last   = 1'b0;
    no_seq = (mode == MODE_CFB);
    if (load) begin
      trg  = 2'd1;
      src  = SRC_DIN;
      last = 1'b1;
    end else begin
      case (mode)
        MODE_ECB: begin
          src  = (ph == '0) ? SRC_DOUT : SRC_DIN;
          last = (ph == PH_W'(1));
        end
        MODE_CBC: begin
          if (!decrypt) begin
            src  = (ph == '0) ? SRC_DOUT : SRC_XDIN;
            last = (ph == PH_W'(1));
          end else begin
            case (ph)
              PH_W'(0): src = SRC_XIN;
              PH_W'(1): src = SRC_DOUT;
              default:  src = SRC_DIN;
            endcase
            last = (ph == PH_W'(2));
          end
        end
        MODE_OFB: begin
          case (ph)
            PH_W'(0): src = SRC_XIN;
            PH_W'(1): src = SRC_DOUT;
            default:  src = SRC_XDIN;
          endcase
          last = (ph == PH_W'(2));
        end
        default: last = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cmseq_beat_ctr.sv
module cmseq_beat_ctr #(
  parameter int BEATS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign last = (cnt_q == CNT_W'(BEATS - 1));
endmodule

// File: rtl/cmseq_trigger_seq.sv
module cmseq_trigger_seq
  import cmseq_pkg::*;
#(
  parameter int BEATS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                chain_en,
  input  logic [1:0]          mode,
  input  logic [1:0]          op,
  input  logic                core_done,
  input  logic                dout_rd,
  input  logic                din_wr,
  input  logic                xin_wr,
  input  logic                xdin_wr,
  output logic [NUM_TRIG-1:0] trig
);
  localparam int PH_W = 2;

  seq_st_e             st_q;
  logic [PH_W-1:0]     ph_q;
  cm_mode_e            mode_q;
  logic                dec_q;
  logic [NUM_TRIG-1:0] trig_q;

  logic [NUM_SRC-1:0]  stb_v;
  src_e                cur_src;
  logic [1:0]          cur_trg;
  logic                ph_last;
  logic                no_seq;
  logic                beat_last;
  logic                abort;
  logic                hit;

  assign stb_v = {xdin_wr, xin_wr, din_wr, dout_wr_w()};
  function automatic logic dout_wr_w();
    return dout_rd;
  endfunction

  assign abort = soft_rst || !chain_en;
  assign hit   = (trig_q != '0) && stb_v[cur_src];

  cmseq_step_decode #(.PH_W(PH_W)) u_dec (
    .mode    (mode_q),
    .decrypt (dec_q),
    .load    (st_q == ST_LOAD),
    .ph      (ph_q),
    .src     (cur_src),
    .trg     (cur_trg),
    .last    (ph_last),
    .no_seq  (no_seq)
  );

  cmseq_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk  (clk),
    .rst  (rst),
    .clr  (abort || (hit && beat_last)),
    .inc  (hit),
    .last (beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      trig_q <= '0;
      mode_q <= MODE_ECB;
      dec_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          mode_q <= cm_mode_e'(mode);
          dec_q  <= op[0];
          if (cm_mode_e'(mode) == MODE_ECB) begin
            st_q   <= ST_LOAD;
            trig_q <= trig_onehot(2'd1);
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (core_done && !no_seq) begin
            st_q   <= ST_RUN;
            ph_q   <= '0;
            trig_q <= trig_onehot(2'd0);
          end
        end
        default: begin
          if (hit) begin
            trig_q <= '0;
            if (beat_last) begin
              if (ph_last) begin
                st_q <= ST_WAIT;
                ph_q <= '0;
              end else begin
                ph_q <= ph_q + PH_W'(1);
              end
            end
          end else if (trig_q == '0) begin
            trig_q <= trig_onehot(cur_trg);
          end
        end
      endcase
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/cmseq_trigger_seq_chk.sv
module cmseq_trigger_seq_chk
  import cmseq_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                soft_rst,
  input logic                chain_en,
  input logic                dout_rd,
  input logic                din_wr,
  input logic                xin_wr,
  input logic                xdin_wr,
  input logic [NUM_TRIG-1:0] trig
);
  logic any_stb;
  assign any_stb = dout_rd || din_wr || xin_wr || xdin_wr;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (trig == '0));

  assert_single_line_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig));

  assert_hold_until_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (trig != '0 && !any_stb && chain_en && !soft_rst) |=> $stable(trig));

  assert_no_direct_switch_R8: assert property (@(posedge clk) disable iff (rst)
    (trig != '0) |=> (trig == '0 || trig == $past(trig)));

  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (soft_rst || !chain_en) |=> (trig == '0));
endmodule

bind cmseq_trigger_seq cmseq_trigger_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .soft_rst (soft_rst),
  .chain_en (chain_en),
  .dout_rd  (dout_rd),
  .din_wr   (din_wr),
  .xin_wr   (xin_wr),
  .xdin_wr  (xdin_wr),
  .trig     (trig)
);

// File: tb/cmseq_trigger_seq_test.sv
module cmseq_trigger_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS = 8;
  // strobe indices: 0 dout, 1 din, 2 xin, 3 xdin
  localparam int S_DOUT = 0, S_DIN = 1, S_XIN = 2, S_XDIN = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       srst = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] op = 2'b00;
  logic       done = 1'b0;
  logic [3:0] stb = 4'b0;
  logic [2:0] trig;

  int    nchk = 0;
  int    nfail = 0;
  bit    fin = 1'b0;
  string cur_req = "R1";

  // reference model state
  int         q[$];
  bit         m_idle = 1'b1;
  int         lm = 0;
  int         lo = 0;
  logic [2:0] exp_trig = 3'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmseq_trigger_seq #(.BEATS(BEATS)) uut (
    .clk(clk), .rst(rst), .soft_rst(srst), .chain_en(en),
    .mode(mode), .op(op), .core_done(done),
    .dout_rd(stb[0]), .din_wr(stb[1]), .xin_wr(stb[2]), .xdin_wr(stb[3]),
    .trig(trig)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void push_phase(input int t, input int s);
    for (int i = 0; i < BEATS; i++) q.push_back(t * 4 + s);
  endfunction

  function automatic void push_pass();
    bit dec;
    dec = (lo == 1 || lo == 3);
    case (lm)
      0: begin push_phase(0, S_DOUT); push_phase(1, S_DIN); end
      1: if (!dec) begin
           push_phase(0, S_DOUT); push_phase(1, S_XDIN);
         end else begin
           push_phase(0, S_XIN); push_phase(1, S_DOUT); push_phase(2, S_DIN);
         end
      2: begin push_phase(0, S_XIN); push_phase(1, S_DOUT); push_phase(2, S_XDIN); end
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst || srst || !en) begin
      q.delete();
      m_idle   = 1'b1;
      exp_trig = 3'b0;
    end else if (m_idle) begin
      m_idle = 1'b0;
      lm = int'(mode);
      lo = int'(op);
      if (lm == 0) push_phase(1, S_DIN);
      exp_trig = (q.size() > 0) ? 3'(1 << (q[0] / 4)) : 3'b0;
    end else if (exp_trig != 3'b0) begin
      if (stb[q[0] % 4]) begin
        void'(q.pop_front());
        exp_trig = 3'b0;
      end
    end else if (q.size() > 0) begin
      exp_trig = 3'(1 << (q[0] / 4));
    end else if (done && lm != 3) begin
      push_pass();
      exp_trig = 3'(1 << (q[0] / 4));
    end
  end

  always @(negedge clk) begin
    if (!fin) chk(trig === exp_trig, {cur_req, " per-cycle"}, int'(trig), int'(exp_trig));
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic serve(input int src, input int trg, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (trig == 3'b0 && w < 20) begin @(negedge clk); w++; end
      chk(trig == 3'(1 << trg), req, int'(trig), 1 << trg);
      stb[src] = 1'b1;
      @(negedge clk);
      stb[src] = 1'b0;
    end
  endtask

  task automatic start(input logic [1:0] m, input logic [1:0] o);
    en = 1'b0;
    tick(1);
    mode = m; op = o; en = 1'b1;
    tick(1);
  endtask

  task automatic pulse_done();
    done = 1'b1;
    tick(1);
    done = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!fin) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
        fin = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    cur_req = "R1";
    chk(trig == 3'b0, "R1 reset state", int'(trig), 0);
    rst = 1'b0;
    tick(1);
    done = 1'b1; stb = 4'hF;
    tick(2);
    done = 1'b0; stb = 4'h0;
    tick(1);
    chk(trig == 3'b0, "R1 disabled ignores inputs", int'(trig), 0);

    // ECB load, wrong strobes held off (R3, R8)
    cur_req = "R3";
    start(2'b00, 2'b00);
    tick(1);
    chk(trig == 3'b010, "R3 ECB first load on trig1", int'(trig), 2);
    stb[S_DOUT] = 1'b1; stb[S_XIN] = 1'b1;
    tick(2);
    stb = 4'h0;
    tick(1);
    chk(trig == 3'b010, "R8 wrong strobe not counted", int'(trig), 2);
    serve(S_DIN, 1, BEATS, "R3 ECB load din");
    tick(3);
    chk(trig == 3'b0, "R9 waits after eight loads", int'(trig), 0);
    stb[S_DOUT] = 1'b1; tick(1); stb = 4'h0;
    pulse_done();
    serve(S_DOUT, 0, 3, "R3 ECB dout");
    cur_req = "R10";
    pulse_done();
    serve(S_DOUT, 0, BEATS - 3, "R9 ECB dout remaining");
    serve(S_DIN, 1, BEATS, "R3 ECB din");
    tick(2);
    chk(trig == 3'b0, "R10 idle between passes", int'(trig), 0);
    pulse_done();
    serve(S_DOUT, 0, BEATS, "R10 second pass dout");
    serve(S_DIN, 1, BEATS, "R10 second pass din");

    cur_req = "R4";
    start(2'b01, 2'b00);
    pulse_done();
    serve(S_DOUT, 0, BEATS, "R4 CBC enc dout");
    serve(S_XDIN, 1, BEATS, "R4 CBC enc xdin");

    cur_req = "R5";
    start(2'b01, 2'b11);
    pulse_done();
    serve(S_XIN, 0, BEATS, "R5 CBC dec xin");
    serve(S_DOUT, 1, BEATS, "R5 CBC dec dout");
    serve(S_DIN, 2, BEATS, "R5 CBC dec din");

    cur_req = "R6";
    start(2'b10, 2'b01);
    pulse_done();
    serve(S_XIN, 0, BEATS, "R6 OFB dec xin");
    serve(S_DOUT, 1, BEATS, "R6 OFB dec dout");
    serve(S_XDIN, 2, BEATS, "R6 OFB dec xdin");
    start(2'b10, 2'b00);
    pulse_done();
    serve(S_XIN, 0, BEATS, "R6 OFB enc xin");
    serve(S_DOUT, 1, BEATS, "R6 OFB enc dout");
    serve(S_XDIN, 2, BEATS, "R6 OFB enc xdin");

    cur_req = "R7";
    start(2'b11, 2'b00);
    pulse_done();
    tick(4);
    chk(trig == 3'b0, "R7 CFB raises nothing", int'(trig), 0);

    cur_req = "R12";
    start(2'b01, 2'b00);
    mode = 2'b10; op = 2'b01;
    tick(1);
    pulse_done();
    serve(S_DOUT, 0, BEATS, "R12 sampled CBC enc dout");
    serve(S_XDIN, 1, BEATS, "R12 sampled CBC enc xdin");

    cur_req = "R11";
    start(2'b10, 2'b00);
    pulse_done();
    serve(S_XIN, 0, 3, "R11 before soft reset");
    srst = 1'b1;
    tick(1);
    srst = 1'b0;
    chk(trig == 3'b0, "R11 soft reset clears", int'(trig), 0);
    tick(1);
    pulse_done();
    serve(S_XIN, 0, BEATS, "R11 restart full phase");
    serve(S_DOUT, 1, 2, "R11 second phase");
    en = 1'b0;
    tick(1);
    chk(trig == 3'b0, "R11 disable clears", int'(trig), 0);
    tick(2);

    fin = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule